// File: doc/BRIEF.md
# Streaming Radix-2 Frequency-Split FFT Stage

This block is one stage of a streaming radix-2 decimation-in-frequency FFT. Samples arrive one complex value per qualified cycle. Each sample is paired with the sample that arrives a fixed distance `SPAN` later. The stage parks the first `SPAN` samples of every block of `2*SPAN` in a delay memory. It then combines each parked sample with its partner: the sum leaves at once, and the difference, after rotation by a twiddle factor, goes back into the same memory slot. The rotated differences leave while the first half of the following block is being parked. The output is therefore one serial stream: `SPAN` sums, then `SPAN` rotated differences.

The twiddle factor can come from a computed table of quantised cosine and sine values. For the last stages of a pipeline, a multiplier-free variant is also available, where the rotation is only 1 or -j. An optional one-bit scaling on both butterfly outputs keeps the word width constant without overflow. Cycles with no input valid are idle and change nothing. A stage is used by feeding its output stream directly into the next stage, whose `SPAN` is half as large.

Top module: `dif_sdf_stage`

## Requirements
- R1: For the input at position `SPAN+k` of a block (k in 0..SPAN-1), the cycle after it is accepted shows `out_valid`=1. The output value is the folded sum of the parked sample k and this sample.
- R2: The first `SPAN` accepted samples after reset produce no output (`out_valid`=0 the cycle after each).
- R3: The rotated difference for pair k appears the cycle after sample k of the next block is accepted. Results come out in k order, with `out_valid`=1.
- R4: In table mode the rotation factor is `C - jS`. C = floor(cos(pi*k/SPAN)*2^(TW_W-2)+0.5) and S is formed the same way from the sine. Real part = d_re*C + d_im*S and imaginary part = d_im*C - d_re*S. Each is rounded by adding 2^(TW_W-3), arithmetically shifting right by TW_W-2, and keeping the low `W` bits.
- R5: Folding a full-precision (W+1 bit) sum or difference gives a `W`-bit result. With `SCALE`=1 this is an arithmetic right shift by one (floor). With `SCALE`=0 it is the low `W` bits (wrap-around).
- R6: In swap mode (no multiplier) the factor is 1 when 2k < SPAN. Otherwise it is -j, giving real = d_im and imaginary = -d_re, wrapped to `W` bits.
- R7: A cycle with `in_valid`=0 advances no position and stores nothing. The next cycle has `out_valid`=0. `out_valid` is 1 only in the cycle after an accepted sample.
- R8: Synchronous reset clears `out_valid`, the block position and the pending-difference state. The next accepted sample is position 0, and differences stored before reset are never emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the input sample |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_valid | output | 1 | Marks a result on the output |
| out_re | output | W | Output real part |
| out_im | output | W | Output imaginary part |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `SPAN`=8, table twiddles and `SCALE`=1, so every nontrivial rotation angle of an 16-point stage and the floor behaviour of the halving are reached. The other uses `SPAN`=2, swap mode and `SCALE`=0, so the -j branch and wrap-around of full-scale sums are reached. Random gaps in `in_valid` and a reset in the middle of a block exercise position holding and the discarding of pending differences.

// File: rtl/fft_stage_pkg.sv
package fft_stage_pkg;

  typedef enum logic [0:0] {
    TW_TABLE = 1'b0,
    TW_SWAP  = 1'b1
  } tw_mode_e;

  // quantised cosine / sine of pi*k/span, scaled by 2^frac, round half up
  function automatic int q_cos(input int k, input int span, input int frac);
    real ang;
    ang = $acos(-1.0) * real'(k) / real'(span);
    return $rtoi($floor($cos(ang) * (2.0 ** frac) + 0.5));
  endfunction

  function automatic int q_sin(input int k, input int span, input int frac);
    real ang;
    ang = $acos(-1.0) * real'(k) / real'(span);
    return $rtoi($floor($sin(ang) * (2.0 ** frac) + 0.5));
  endfunction

endpackage

// File: rtl/stage_ctrl.sv
module stage_ctrl #(
  parameter int SPAN = 8,
  localparam int AW = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic [AW-1:0] k_idx,
  output logic          upper_half,
  output logic          pend_ready
);
  localparam int CW   = $clog2(SPAN) + 1;
  localparam int LAST = 2 * SPAN - 1;

  logic [CW-1:0] cnt;
  logic          frame_end;

  assign frame_end  = in_valid && (cnt == CW'(LAST));
  assign upper_half = cnt[CW-1];

  generate
    if (SPAN == 1) begin : g_k_one
      assign k_idx = '0;
    end else begin : g_k_many
      assign k_idx = cnt[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      pend_ready <= 1'b0;
    end else if (in_valid) begin
      cnt <= frame_end ? '0 : cnt + 1'b1;
      if (frame_end) pend_ready <= 1'b1;
    end
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (cnt == '0) && pend_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cnt));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt == '0) && !pend_ready);

endmodule

// File: rtl/stage_delay_mem.sv
module stage_delay_mem #(
  parameter int SPAN = 8,
  parameter int DW   = 32,
  localparam int AW  = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot [SPAN];

  // read-before-write: the old slot content is used in the same cycle
  always_comb rdata = slot[addr];

  always_ff @(posedge clk) begin
    if (we) slot[addr] <= wdata;
  end

endmodule

// File: rtl/stage_butterfly.sv
module stage_butterfly #(
  parameter int W     = 16,
  parameter bit SCALE = 1'b1
) (
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic signed [W-1:0] s_re,
  output logic signed [W-1:0] s_im,
  output logic signed [W-1:0] d_re,
  output logic signed [W-1:0] d_im
);
  // reduce a W+1 bit result to W bits: halve (floor) or wrap
  function automatic logic signed [W-1:0] fold(input logic signed [W:0] v);
    if (SCALE) return v[W:1];
    else       return v[W-1:0];
  endfunction

  function automatic logic signed [W:0] add_w(input logic signed [W-1:0] x,
                                              input logic signed [W-1:0] y);
    logic signed [W:0] xe, ye;
    xe = x;
    ye = y;
    return xe + ye;
  endfunction

  function automatic logic signed [W:0] sub_w(input logic signed [W-1:0] x,
                                              input logic signed [W-1:0] y);
    logic signed [W:0] xe, ye;
    xe = x;
    ye = y;
    return xe - ye;
  endfunction

  always_comb begin
    s_re = fold(add_w(a_re, b_re));
    s_im = fold(add_w(a_im, b_im));
    d_re = fold(sub_w(a_re, b_re));
    d_im = fold(sub_w(a_im, b_im));
  end

endmodule

// File: rtl/stage_twiddle.sv
module stage_twiddle #(
  parameter int W    = 16,
  parameter int TW_W = 16,
  parameter int SPAN = 8,
  parameter fft_stage_pkg::tw_mode_e MODE = fft_stage_pkg::TW_TABLE,
  localparam int AW  = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       k_idx,
  input  logic signed [W-1:0] d_re,
  input  logic signed [W-1:0] d_im,
  output logic signed [W-1:0] r_re,
  output logic signed [W-1:0] r_im
);
  localparam int FRAC = TW_W - 2;
  localparam int PW   = W + TW_W + 1;

  function automatic logic signed [W-1:0] round_keep(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] t;
    t = p + (PW'(1) <<< (FRAC - 1));
    return t[FRAC+W-1:FRAC];
  endfunction

  function automatic logic signed [PW-1:0] mul(input logic signed [W-1:0] x,
                                               input logic signed [TW_W-1:0] c);
    logic signed [PW-1:0] xe, ce;
    xe = x;
    ce = c;
    return xe * ce;
  endfunction

  function automatic logic signed [W-1:0] neg_w(input logic signed [W-1:0] x);
    return -x;
  endfunction

  generate
    if (MODE == fft_stage_pkg::TW_TABLE) begin : g_table
      logic signed [TW_W-1:0] cos_t [SPAN];
      logic signed [TW_W-1:0] sin_t [SPAN];
      logic signed [TW_W-1:0] c_sel, s_sel;

      for (genvar g = 0; g < SPAN; g++) begin : g_rom
        assign cos_t[g] = TW_W'(fft_stage_pkg::q_cos(g, SPAN, FRAC));
        assign sin_t[g] = TW_W'(fft_stage_pkg::q_sin(g, SPAN, FRAC));
      end

      assign c_sel = cos_t[k_idx];
      assign s_sel = sin_t[k_idx];

      always_comb begin
        r_re = round_keep(mul(d_re, c_sel) + mul(d_im, s_sel));
        r_im = round_keep(mul(d_im, c_sel) - mul(d_re, s_sel));
      end

      // a unit factor at position 0 must survive quantisation and rounding
      assert_unit_twiddle_R4: assert property (@(posedge clk) disable iff (rst)
        (k_idx == '0) |-> (r_re == d_re) && (r_im == d_im));
    end else begin : g_swap
      logic rot_j;
      assign rot_j = (2 * int'(k_idx)) >= SPAN;

      always_comb begin
        if (rot_j) begin
          r_re = d_im;
          r_im = neg_w(d_re);
        end else begin
          r_re = d_re;
          r_im = d_im;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dif_sdf_stage.sv
module dif_sdf_stage #(
  parameter int W     = 16,
  parameter int TW_W  = 16,
  parameter int SPAN  = 8,
  parameter bit SCALE = 1'b1,
  parameter fft_stage_pkg::tw_mode_e MODE = fft_stage_pkg::TW_TABLE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic                out_valid,
  output logic signed [W-1:0] out_re,
  output logic signed [W-1:0] out_im
);
  localparam int AW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int DW = 2 * W;

  logic [AW-1:0]       k_idx;
  logic                upper_half, pend_ready;
  logic [DW-1:0]       mem_rd, mem_wr;
  logic signed [W-1:0] m_re, m_im;
  logic signed [W-1:0] s_re, s_im, d_re, d_im, r_re, r_im;
  logic                emit_sum, emit_diff;

  stage_ctrl #(.SPAN(SPAN)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .k_idx(k_idx), .upper_half(upper_half), .pend_ready(pend_ready)
  );

  stage_delay_mem #(.SPAN(SPAN), .DW(DW)) u_mem (
    .clk(clk), .we(in_valid), .addr(k_idx), .wdata(mem_wr), .rdata(mem_rd)
  );

  assign m_re = mem_rd[DW-1:W];
  assign m_im = mem_rd[W-1:0];

  stage_butterfly #(.W(W), .SCALE(SCALE)) u_bfly (
    .a_re(m_re), .a_im(m_im), .b_re(in_re), .b_im(in_im),
    .s_re(s_re), .s_im(s_im), .d_re(d_re), .d_im(d_im)
  );

  stage_twiddle #(.W(W), .TW_W(TW_W), .SPAN(SPAN), .MODE(MODE)) u_tw (
    .clk(clk), .rst(rst), .k_idx(k_idx),
    .d_re(d_re), .d_im(d_im), .r_re(r_re), .r_im(r_im)
  );

  // lower half parks the input, upper half parks the rotated difference
  assign mem_wr    = upper_half ? {r_re, r_im} : {in_re, in_im};
  assign emit_sum  = in_valid && upper_half;
  assign emit_diff = in_valid && !upper_half && pend_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= emit_sum || emit_diff;
      if (emit_sum) begin
        out_re <= s_re;
        out_im <= s_im;
      end else if (emit_diff) begin
        out_re <= m_re;
        out_im <= m_im;
      end
    end
  end

  assert_sum_out_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && upper_half) |=> out_valid);

  assert_no_early_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !upper_half && !pend_ready) |=> !out_valid);

  assert_qualified_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_reset_out_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

endmodule

// File: tb/dif_sdf_stage_test.sv
`timescale 1ns/1ps
module dif_sdf_stage_test;
  localparam int W = 16;
  localparam int F = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic ov [2];
  logic signed [W-1:0] ore [2];
  logic signed [W-1:0] oim [2];

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dif_sdf_stage #(.W(W), .TW_W(16), .SPAN(8), .SCALE(1'b1),
                  .MODE(fft_stage_pkg::TW_TABLE)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[0]), .out_re(ore[0]), .out_im(oim[0]));

  dif_sdf_stage #(.W(W), .TW_W(16), .SPAN(2), .SCALE(1'b0),
                  .MODE(fft_stage_pkg::TW_SWAP)) uut_swap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[1]), .out_re(ore[1]), .out_im(oim[1]));

  // bench-side model state, per instance
  int  span_of [2] = '{8, 2};
  bit  halve   [2] = '{1'b1, 1'b0};
  bit  swapm   [2] = '{1'b0, 1'b1};
  int  park_re [2][8], park_im [2][8];
  int  pend_re [2][8], pend_im [2][8];
  int  pos [2];
  bit  have_pend [2];

  function automatic int wrap16(input longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int fold_b(input int inst, input longint v);
    if (halve[inst]) return wrap16(v >>> 1);
    return wrap16(v);
  endfunction

  function automatic int tcos(input int k, input int sp);
    return int'($floor($cos($acos(-1.0) * k / sp) * 16384.0 + 0.5));
  endfunction

  function automatic int tsin(input int k, input int sp);
    return int'($floor($sin($acos(-1.0) * k / sp) * 16384.0 + 0.5));
  endfunction

  task automatic rotate(input int inst, input int k, input int dr, input int di,
                        output int rr, output int ri);
    longint c, s, pr, pi;
    if (swapm[inst]) begin
      if (2 * k < span_of[inst]) begin rr = dr; ri = di; end
      else begin rr = di; ri = wrap16(-longint'(dr)); end
    end else begin
      c  = tcos(k, span_of[inst]);
      s  = tsin(k, span_of[inst]);
      pr = longint'(dr) * c + longint'(di) * s;
      pi = longint'(di) * c - longint'(dr) * s;
      rr = wrap16((pr + (64'sd1 <<< (F - 1))) >>> F);
      ri = wrap16((pi + (64'sd1 <<< (F - 1))) >>> F);
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin pos[i] = 0; have_pend[i] = 0; end
  endtask

  task automatic step(input bit v, input int re, input int im);
    bit    ev [2];
    int    er [2], ei [2];
    string tag [2];
    int    sp, k, rr, ri;
    @(negedge clk);
    in_valid = v;
    in_re = W'(re);
    in_im = W'(im);
    for (int i = 0; i < 2; i++) begin
      sp = span_of[i];
      ev[i] = 0; er[i] = 0; ei[i] = 0; tag[i] = "R7";
      if (v) begin
        if (pos[i] < sp) begin
          k = pos[i];
          ev[i] = have_pend[i];
          er[i] = pend_re[i][k];
          ei[i] = pend_im[i][k];
          tag[i] = have_pend[i] ? "R3" : "R2";
          park_re[i][k] = re;
          park_im[i][k] = im;
        end else begin
          k = pos[i] - sp;
          ev[i] = 1;
          tag[i] = "R1";
          er[i] = fold_b(i, longint'(park_re[i][k]) + re);
          ei[i] = fold_b(i, longint'(park_im[i][k]) + im);
          rotate(i, k, fold_b(i, longint'(park_re[i][k]) - re),
                 fold_b(i, longint'(park_im[i][k]) - im), rr, ri);
          pend_re[i][k] = rr;
          pend_im[i][k] = ri;
        end
        pos[i]++;
        if (pos[i] == 2 * sp) begin pos[i] = 0; have_pend[i] = 1; end
      end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      check(ov[i] == ev[i], tag[i], $sformatf("inst%0d out_valid", i),
            int'(ov[i]), int'(ev[i]));
      if (ev[i]) begin
        // value checks on table copy also cover R4/R5, swap copy R6/R5
        check(int'(ore[i]) == er[i], tag[i], $sformatf("inst%0d out_re (R4 R5 R6)", i),
              int'(ore[i]), er[i]);
        check(int'(oim[i]) == ei[i], tag[i], $sformatf("inst%0d out_im (R4 R5 R6)", i),
              int'(oim[i]), ei[i]);
      end
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (cycles) @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++)
      check(ov[i] == 1'b0, "R8", $sformatf("inst%0d out_valid in reset", i), int'(ov[i]), 0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  function automatic int rnd_val();
    return int'($urandom_range(16383)) - 8192;
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    model_reset();
    do_reset(3);

    // directed: full-scale corners and floor behaviour of the halving (R5)
    step(1, 32767, -32768);
    step(1, -1, 7);
    step(1, 32767, -32768);
    step(1, -2, 0);
    step(1, 100, -100);
    step(1, 0, 0);
    step(1, 1, 1);
    step(1, -3, 3);
    step(1, 32767, -32768);
    step(1, -2, 2);
    step(1, -32768, 32767);
    step(1, -1, -1);
    step(1, 5, 5);
    step(1, 0, 0);
    step(1, -1, 2);
    step(1, 3, -3);
    // idle gap: no output, nothing stored (R7)
    step(0, 1234, 1234);
    step(0, -999, 42);
    for (int j = 0; j < 16; j++) step(1, 1000 * j - 8000, 4000 - 500 * j);

    // constrained random with gaps
    for (int j = 0; j < 900; j++) begin
      if ($urandom_range(3) == 0) step(0, rnd_val(), rnd_val());
      else step(1, rnd_val(), rnd_val());
    end

    // reset inside a block: pending differences must be dropped (R8)
    for (int j = 0; j < 21; j++) step(1, rnd_val(), rnd_val());
    do_reset(2);
    for (int j = 0; j < 40; j++) begin
      if ($urandom_range(4) == 0) step(0, rnd_val(), rnd_val());
      else step(1, rnd_val(), rnd_val());
    end
    // flush
    for (int j = 0; j < 20; j++) step(1, 0, 0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule